// File: doc/BRIEF.md
# Display Refresh Clock Generator and Scan Sequencer

This block produces the display clock and the refresh scan timing for one stage of a cascaded LED matrix driver chain. The display clock comes from one of two sources. The first is an internal free-running oscillator, modelled as a divider of the system clock. The second is an external oscillator input, which is synchronised and edge-detected. The external path can optionally be divided by eight. The display clock appears as a single-cycle `disp_tick` strobe in the system clock domain.

Each display tick advances a frame counter. The frame counter gives the current scan position. One refresh frame lasts a fixed number of display ticks, and a one-cycle pulse marks the end of each frame.

The internal oscillator's square wave is exported on `osc_out`. A master stage can therefore drive the external oscillator input of slave stages. A sleep control stops the oscillator and holds the scan idle.

Top module: `disp_scan`

## Requirements
- R1: During and right after reset, `scan_pos` is 0, `frame_done` is 0, `disp_tick` is 0 and `osc_out` is 0.
- R2: With `use_ext`=1 and `div8`=0, each rising edge of `ext_osc` gives exactly one `disp_tick`.
- R3: With `use_ext`=1 and `div8`=1, one `disp_tick` is given per 8 rising edges of `ext_osc`. Every change of `div8` restarts the divide-by-8 count at zero.
- R4: With `use_ext`=0, the tick rate is set by the internal oscillator: one tick per 2*INT_HALF clocks. This rate is the same for either value of `div8`, and `ext_osc` has no effect on it.
- R5: `scan_pos` advances by one on each `disp_tick` and wraps from FRAME_LEN-1 (511) to 0. `frame_done` is high for exactly one clock, the clock after the tick that wraps it.
- R6: While `awake`=0, no `disp_tick` occurs, `scan_pos` is 0, `osc_out` is low, and the divide-by-8 count is cleared.
- R7: When `awake` returns to 1, scanning starts from `scan_pos`=0.
- R8: While `awake`=1, `osc_out` is a square wave with a period of 2*INT_HALF clocks. It is suitable as the `ext_osc` of a slave stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| awake | input | 1 | 1 = run, 0 = sleep |
| use_ext | input | 1 | 1 = external oscillator selected |
| div8 | input | 1 | Divide the external oscillator by 8 |
| ext_osc | input | 1 | External oscillator input (asynchronous) |
| osc_out | output | 1 | Internal oscillator export for slave stages |
| disp_tick | output | 1 | One-cycle display clock strobe |
| scan_pos | output | 9 | Current scan position in the frame |
| frame_done | output | 1 | One-cycle pulse at frame wrap |

## Verification
A corrupted prescale count shows as a display tick that arrives too early or too late. This is visible within eight external edges after a `div8` change. A stuck or misloaded frame counter shows at most 512 ticks later: either no `frame_done`, or a pulse at the wrong `scan_pos`. Sleep faults show at once as a moving `scan_pos`, ticks, or oscillator activity while `awake` is low.

// File: rtl/disp_scan.sv
module disp_scan #(
  parameter int INT_HALF  = 16,
  parameter int FRAME_LEN = 512,
  parameter int PRESCALE  = 8,
  localparam int SCAN_W   = $clog2(FRAME_LEN),
  localparam int IC_W     = (INT_HALF > 1) ? $clog2(INT_HALF) : 1,
  localparam int PS_W     = $clog2(PRESCALE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              awake,
  input  logic              use_ext,
  input  logic              div8,
  input  logic              ext_osc,
  output logic              osc_out,
  output logic              disp_tick,
  output logic [SCAN_W-1:0] scan_pos,
  output logic              frame_done
);

  logic [IC_W-1:0] int_cnt;
  logic            int_lvl;
  logic            int_tick;
  logic [2:0]      ext_sh;
  logic            ext_rise;
  logic [PS_W-1:0] ps_cnt;
  logic            div8_q;
  logic            ext_tick;

  // internal oscillator: square wave, half period INT_HALF clocks
  assign int_tick = awake && !int_lvl && (int_cnt == IC_W'(INT_HALF - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !awake) begin
      int_cnt <= '0;
      int_lvl <= 1'b0;
    end else if (int_cnt == IC_W'(INT_HALF - 1)) begin
      int_cnt <= '0;
      int_lvl <= !int_lvl;
    end else begin
      int_cnt <= int_cnt + 1'b1;
    end
  end

  assign osc_out = int_lvl;

  // external input: two-flop synchroniser plus edge detector
  always_ff @(posedge clk) begin
    if (!rst_n) ext_sh <= '0;
    else        ext_sh <= {ext_sh[1:0], ext_osc};
  end

  assign ext_rise = ext_sh[1] && !ext_sh[2];

  // prescaler restarts on any div8 change or on sleep
  always_ff @(posedge clk) begin
    if (!rst_n) div8_q <= 1'b0;
    else        div8_q <= div8;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !awake || (div8 != div8_q)) ps_cnt <= '0;
    else if (div8 && ext_rise)                ps_cnt <= ps_cnt + 1'b1;
  end

  assign ext_tick  = ext_rise && (!div8 || ps_cnt == PS_W'(PRESCALE - 1))
                     && (div8 == div8_q);
  assign disp_tick = awake && (use_ext ? ext_tick : int_tick);

  // frame counter
  always_ff @(posedge clk) begin
    if (!rst_n || !awake) begin
      scan_pos   <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= disp_tick && (scan_pos == SCAN_W'(FRAME_LEN - 1));
      if (disp_tick)
        scan_pos <= (scan_pos == SCAN_W'(FRAME_LEN - 1)) ? '0 : scan_pos + 1'b1;
    end
  end

endmodule

module disp_scan_chk #(
  parameter int FRAME_LEN = 512,
  localparam int SCAN_W   = $clog2(FRAME_LEN)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              awake,
  input logic              osc_out,
  input logic              disp_tick,
  input logic [SCAN_W-1:0] scan_pos,
  input logic              frame_done
);

  assert_sleep_no_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !awake |-> !disp_tick);
  assert_sleep_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !awake |=> (scan_pos == '0) && !osc_out);
  assert_wake_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(awake) |-> scan_pos == '0);
  assert_scan_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_tick && scan_pos != SCAN_W'(FRAME_LEN - 1)) |=> scan_pos == $past(scan_pos) + 1'b1);
  assert_scan_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_tick && scan_pos == SCAN_W'(FRAME_LEN - 1)) |=> (scan_pos == '0) && frame_done);
  assert_scan_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (awake && !disp_tick) |=> $stable(scan_pos));
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

endmodule

bind disp_scan disp_scan_chk #(.FRAME_LEN(FRAME_LEN)) u_disp_scan_chk (
  .clk(clk), .rst_n(rst_n), .awake(awake), .osc_out(osc_out),
  .disp_tick(disp_tick), .scan_pos(scan_pos), .frame_done(frame_done)
);

// File: tb/test_disp_scan.sv
module test_disp_scan;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0, awake = 1'b0, use_ext = 1'b0, div8 = 1'b0, ext_osc = 1'b0;
  logic osc_out, disp_tick, frame_done;
  logic [8:0] scan_pos;
  int checks = 0, failures = 0;
  int ticks = 0, frames = 0, osc_rises = 0;
  logic osc_prev = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  disp_scan #(.INT_HALF(HALF)) i_disp_scan (
    .clk(clk), .rst_n(rst_n), .awake(awake), .use_ext(use_ext), .div8(div8),
    .ext_osc(ext_osc), .osc_out(osc_out), .disp_tick(disp_tick),
    .scan_pos(scan_pos), .frame_done(frame_done)
  );

  always @(negedge clk) begin
    if (disp_tick) ticks++;
    if (frame_done) frames++;
    if (osc_out && !osc_prev) osc_rises++;
    osc_prev = osc_out;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_range(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ext_osc = 1'b1;
      repeat (2) @(negedge clk);
      ext_osc = 1'b0;
      @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic setmode(input logic e, input logic d);
    @(negedge clk) use_ext = e; div8 = d;
    repeat (4) @(negedge clk);
  endtask

  // {use_ext, div8, ext edges, expected ticks}
  localparam int VEC [0:4][0:3] = '{
    '{1, 0, 20, 20},
    '{1, 0,  5,  5},
    '{1, 1, 16,  2},
    '{1, 1, 24,  3},
    '{1, 0,  1,  1}
  };

  initial begin
    repeat (3) @(negedge clk);
    check("R1 scan_pos", scan_pos, 0);
    check("R1 frame_done", frame_done, 0);
    check("R1 disp_tick", disp_tick, 0);
    check("R1 osc_out", osc_out, 0);
    rst_n = 1'b1;
    awake = 1'b1;

    for (int v = 0; v < 5; v++) begin
      setmode(VEC[v][0][0], VEC[v][1][0]);
      ticks = 0;
      pulses(VEC[v][2]);
      check(VEC[v][1] != 0 ? "R3 divided ext ticks" : "R2 direct ext ticks", ticks, VEC[v][3]);
    end

    // R3: div8 change restarts the count
    setmode(1, 1);
    ticks = 0;
    pulses(5);
    setmode(1, 0);
    setmode(1, 1);
    pulses(3);
    check("R3 restart after div8 change", ticks, 0);
    pulses(5);
    check("R3 tick on 8th edge after restart", ticks, 1);

    // R4: internal oscillator ignores div8 and ext_osc
    setmode(0, 0);
    ticks = 0;
    repeat (80) @(negedge clk);
    check_range("R4 internal rate div8=0", ticks, 9, 11);
    setmode(0, 1);
    ticks = 0;
    pulses(10);
    check_range("R4 internal rate div8=1 with ext edges", ticks, 5, 7);

    // R8: exported oscillator
    osc_rises = 0;
    repeat (80) @(negedge clk);
    check_range("R8 osc_out period", osc_rises, 9, 11);

    // R6: sleep
    setmode(1, 0);
    @(negedge clk) awake = 1'b0;
    ticks = 0; osc_rises = 0;
    pulses(10);
    check("R6 no ticks in sleep", ticks, 0);
    check("R6 scan_pos held 0", scan_pos, 0);
    check("R6 osc_out quiet", osc_rises + osc_out, 0);

    // R6: sleep clears the prescaler
    @(negedge clk) awake = 1'b1;
    setmode(1, 1);
    ticks = 0;
    pulses(5);
    @(negedge clk) awake = 1'b0;
    @(negedge clk) awake = 1'b1;
    pulses(3);
    check("R6 prescaler cleared by sleep", ticks, 0);

    // R7 and R5: full frame from zero
    setmode(1, 0);
    @(negedge clk) awake = 1'b0;
    @(negedge clk) awake = 1'b1;
    @(negedge clk);
    check("R7 scan_pos after wake", scan_pos, 0);
    frames = 0;
    pulses(511);
    check("R5 scan_pos at last", scan_pos, 511);
    check("R5 no frame_done before wrap", frames, 0);
    pulses(1);
    check("R5 wrap to 0", scan_pos, 0);
    check("R5 one frame_done", frames, 1);

    // R5 with prescaler: 4096 external edges per frame
    setmode(1, 1);
    @(negedge clk) awake = 1'b0;
    @(negedge clk) awake = 1'b1;
    frames = 0;
    pulses(4095);
    check("R5 no frame before 4096 edges", frames, 0);
    pulses(1);
    check("R5 frame after 4096 edges", frames, 1);
    check("R5 scan_pos wrapped", scan_pos, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule